// File: doc/BRIEF.md
# Format-Selectable 7:1 Pixel Lane Serializer

This block turns a parallel video pixel (8-bit red, green and blue plus four control bits) into seven serial bit slots per data lane, for a four-lane low-voltage differential display link. A companion clock-lane bit runs alongside the data lanes with a fixed per-slot pattern, so that the receiver can find the pixel boundary. The block runs on the fast bit clock. A slot-advance strobe `bit_en` marks each bit period, and seven strobes make one pixel period.

A two-bit format selector picks one of three lane packings. The first is an 18-bit packing on three lanes, which uses colour bits 5..0. The second is a 24-bit packing where lanes 0..2 carry colour bits 7..2 and lane 3 carries the two low bits. The third is a 24-bit packing where lanes 0..2 match the 18-bit packing and lane 3 carries bits 7..6. The pixel and the selector are captured together at the start of each pixel period. A change on either input therefore takes effect only at a pixel boundary. The differential drivers, the bit-clock PLL and the video timing generator sit outside this block.

Top module: `lvdsp_serializer`

## Requirements
- R1: A slot counter runs 0,1,...,6,0 and advances by one on each cycle where `bit_en` is high. While `bit_en` is low, `lane_o` and `clk_lane_o` hold their values.
- R2: The clock lane bit is 1 for slots 0, 1, 5 and 6 and 0 for slots 2, 3 and 4.
- R3: When `fmt` is 2'b00 or 2'b11 (18-bit), the lanes carry the following bits in slots 0..6. Lane 0: G0,R5,R4,R3,R2,R1,R0. Lane 1: B1,B0,G5,G4,G3,G2,G1. Lane 2: CTL2,CTL1,CTL0,B5,B4,B3,B2. Lane 3 stays 0, and colour bits 7..6 and CTL3 have no effect.
- R4: When `fmt` is 2'b01, lanes 0..2 follow the R3 layout with every colour index raised by two (lane 0: G2,R7..R2). Lane 3 carries CTL3,B1,B0,G1,G0,R1,R0.
- R5: When `fmt` is 2'b10, lanes 0..2 follow the R3 layout exactly. Lane 3 carries CTL3,B7,B6,G7,G6,R7,R6.
- R6: The control bits are assigned as CTL0 = `hsync`, CTL1 = `vsync`, CTL2 = `de` and CTL3 = `ctl_spare`.
- R7: The pixel inputs and `fmt` are captured only on a `bit_en` cycle at slot 0. `load_o` is high exactly on those cycles. Input changes during slots 1..6 do not alter the pixel that is being sent.
- R8: While `rst_n` is low, the counter returns to slot 0 and all four lanes and the clock lane are driven 0.
- R9: The bit for slot s appears on the outputs in the cycle after the `bit_en` cycle that takes slot s. Slot 0 is sent first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Slot-advance strobe, one per bit period |
| fmt | input | 2 | Lane packing selector, sampled at slot 0 |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| hsync | input | 1 | Horizontal sync (CTL0) |
| vsync | input | 1 | Vertical sync (CTL1) |
| de | input | 1 | Data enable (CTL2) |
| ctl_spare | input | 1 | Spare control bit (CTL3) |
| lane_o | output | 4 | Serial data lane bits, lane i on bit i |
| clk_lane_o | output | 1 | Clock lane bit |
| load_o | output | 1 | High on the cycle the pixel inputs are captured |

## Verification
A slot counter that drifts or wraps at the wrong count shows on the clock lane within one pixel period, because its high-low-high pattern no longer lines up with the pixel boundary. A stale or wrongly loaded lane word appears as a wrong bit on the very next `bit_en` cycle. A wrong packing choice appears as a swapped colour bit within the seven slots of the affected pixel. The bench compares every slot of every pixel, using bit-distinct colour values, under back-to-back strobes, sparse strobes and mid-pixel input changes.

// File: rtl/lvdsp_pkg.sv
package lvdsp_pkg;
    localparam int SLOTS     = 7;
    localparam int LANES     = 4;
    localparam int CW        = 8;
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int MAP_LANES = 3;
    // bit s is the clock lane level in slot s
    localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;

    typedef logic [SLOTS-1:0] lane_word_t;

    typedef enum logic [1:0] {
        FMT_18      = 2'b00,
        FMT_24_HI   = 2'b01,
        FMT_24_LO   = 2'b10,
        FMT_18_ALT  = 2'b11
    } fmt_t;

    typedef struct packed {
        logic [CW-1:0] r;
        logic [CW-1:0] g;
        logic [CW-1:0] b;
        logic [3:0]    ctl;   // {spare, de, vsync, hsync}
    } pixel_t;
endpackage

// File: rtl/lvdsp_slot_seq.sv
module lvdsp_slot_seq
    import lvdsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [SLOT_W-1:0] slot_q,
    output logic              at_first,
    output logic              clk_bit
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    logic [SLOT_W-1:0] slot_d;

    always_comb begin
        slot_d = slot_q;
        if (adv) begin
            slot_d = (slot_q == LAST) ? '0 : slot_q + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign at_first = (slot_q == '0);
    assign clk_bit  = CLK_PATTERN[slot_q];
endmodule

// File: rtl/lvdsp_lane_pack.sv
module lvdsp_lane_pack
    import lvdsp_pkg::*;
#(
    parameter int BASE = 0
) (
    input  pixel_t     px,
    output lane_word_t words [MAP_LANES]
);
    // word bit s is sent in slot s
    assign words[0] = {px.r[BASE+0], px.r[BASE+1], px.r[BASE+2], px.r[BASE+3],
                       px.r[BASE+4], px.r[BASE+5], px.g[BASE+0]};
    assign words[1] = {px.g[BASE+1], px.g[BASE+2], px.g[BASE+3], px.g[BASE+4],
                       px.g[BASE+5], px.b[BASE+0], px.b[BASE+1]};
    assign words[2] = {px.b[BASE+2], px.b[BASE+3], px.b[BASE+4], px.b[BASE+5],
                       px.ctl[0], px.ctl[1], px.ctl[2]};
endmodule

// File: rtl/lvdsp_serializer.sv
module lvdsp_serializer
    import lvdsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic [1:0]       fmt,
    input  logic [7:0]       pix_r,
    input  logic [7:0]       pix_g,
    input  logic [7:0]       pix_b,
    input  logic             hsync,
    input  logic             vsync,
    input  logic             de,
    input  logic             ctl_spare,
    output logic [LANES-1:0] lane_o,
    output logic             clk_lane_o,
    output logic             load_o
);
    typedef struct packed {
        lane_word_t [LANES-1:0] words;
        logic [LANES-1:0]       lanes;
        logic                   ck;
    } ser_state_t;

    ser_state_t st_d, st_q;

    logic [SLOT_W-1:0] slot_q;
    logic              at_first;
    logic              clk_bit;

    pixel_t px;
    assign px = '{r: pix_r, g: pix_g, b: pix_b,
                  ctl: {ctl_spare, de, vsync, hsync}};

    lvdsp_slot_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (bit_en),
        .slot_q   (slot_q),
        .at_first (at_first),
        .clk_bit  (clk_bit)
    );

    // variant 0 packs colour bits 5..0, variant 1 packs bits 7..2
    lane_word_t packs [2][MAP_LANES];
    for (genvar v = 0; v < 2; v++) begin : g_pack
        lvdsp_lane_pack #(.BASE(2 * v)) u_pack (
            .px    (px),
            .words (packs[v])
        );
    end

    lane_word_t [LANES-1:0] fresh;

    always_comb begin
        fresh = '0;
        unique case (fmt_t'(fmt))
            FMT_24_HI: begin
                for (int i = 0; i < MAP_LANES; i++) fresh[i] = packs[1][i];
                fresh[3] = {px.r[0], px.r[1], px.g[0], px.g[1],
                            px.b[0], px.b[1], px.ctl[3]};
            end
            FMT_24_LO: begin
                for (int i = 0; i < MAP_LANES; i++) fresh[i] = packs[0][i];
                fresh[3] = {px.r[6], px.r[7], px.g[6], px.g[7],
                            px.b[6], px.b[7], px.ctl[3]};
            end
            default: begin
                for (int i = 0; i < MAP_LANES; i++) fresh[i] = packs[0][i];
                fresh[3] = '0;
            end
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (bit_en) begin
            if (at_first) st_d.words = fresh;
            for (int i = 0; i < LANES; i++) begin
                st_d.lanes[i] = at_first ? fresh[i][slot_q] : st_q.words[i][slot_q];
            end
            st_d.ck = clk_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lane_o     = st_q.lanes;
    assign clk_lane_o = st_q.ck;
    assign load_o     = rst_n & bit_en & at_first;
endmodule

// File: rtl/lvdsp_checker.sv
module lvdsp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic [1:0] fmt,
    input logic [3:0] lane_o,
    input logic       clk_lane_o,
    input logic       load_o,
    input logic [2:0] slot
);
    p_slot_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= 3'd6);

    p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && slot != 3'd6) |=> slot == 3'($past(slot) + 3'd1));

    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && slot == 3'd6) |=> slot == 3'd0);

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(lane_o) && $stable(clk_lane_o)));

    p_clk_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && (slot == 3'd0 || slot == 3'd1 || slot == 3'd5 || slot == 3'd6))
        |=> clk_lane_o);

    p_clk_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && (slot == 3'd2 || slot == 3'd3 || slot == 3'd4)) |=> !clk_lane_o);

    p_lane3_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && slot == 3'd0 && (fmt == 2'b00 || fmt == 2'b11)) |=> !lane_o[3]);

    p_load_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> (bit_en && slot == 3'd0));

    logic rst_seen_q;
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
        if (rst_seen_q) begin
            a_reset_state_r8: assert (lane_o == 4'd0 && !clk_lane_o && slot == 3'd0);
        end
    end
endmodule

bind lvdsp_serializer lvdsp_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .fmt        (fmt),
    .lane_o     (lane_o),
    .clk_lane_o (clk_lane_o),
    .load_o     (load_o),
    .slot       (slot_q)
);

// File: tb/lvdsp_serializer_bench.sv
module lvdsp_serializer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [1:0] fmt = 2'b00;
    logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic       hsync = 1'b0, vsync = 1'b0, de = 1'b0, ctl_spare = 1'b0;
    logic [3:0] lane_o;
    logic       clk_lane_o;
    logic       load_o;

    int errors = 0;
    int checks = 0;
    bit started = 1'b0;
    logic en_prev = 1'b0;
    logic [4:0] last_out = '0;

    typedef struct {
        logic [4:0] v;   // {clk lane, lane3..lane0}
        string      tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    lvdsp_serializer u_lvdsp_serializer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fmt(fmt),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .hsync(hsync), .vsync(vsync), .de(de), .ctl_spare(ctl_spare),
        .lane_o(lane_o), .clk_lane_o(clk_lane_o), .load_o(load_o)
    );

    task automatic check(input bit ok, input string tag, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // expected bits for one slot, straight from the requirement lists
    function automatic logic [4:0] exp_slot(input logic [1:0] f, input logic [7:0] r,
        input logic [7:0] g, input logic [7:0] b, input logic [3:0] c, input int s);
        int k;
        logic l0, l1, l2, l3, ck;
        k = (f == 2'b01) ? 2 : 0;
        l0 = (s == 0) ? g[k] : r[k + 6 - s];
        l1 = (s == 0) ? b[k+1] : (s == 1) ? b[k] : g[k + 7 - s];
        l2 = (s == 0) ? c[2] : (s == 1) ? c[1] : (s == 2) ? c[0] : b[k + 8 - s];
        case (f)
            2'b01: case (s)
                0: l3 = c[3]; 1: l3 = b[1]; 2: l3 = b[0]; 3: l3 = g[1];
                4: l3 = g[0]; 5: l3 = r[1]; default: l3 = r[0];
            endcase
            2'b10: case (s)
                0: l3 = c[3]; 1: l3 = b[7]; 2: l3 = b[6]; 3: l3 = g[7];
                4: l3 = g[6]; 5: l3 = r[7]; default: l3 = r[6];
            endcase
            default: l3 = 1'b0;
        endcase
        ck = (s <= 1 || s >= 5);
        return {ck, l3, l2, l1, l0};
    endfunction

    // driver: sends one pixel with 'gap' idle cycles before each strobe
    task automatic send(input logic [1:0] f, input logic [7:0] r, input logic [7:0] g,
                        input logic [7:0] b, input logic [3:0] c, input int gap,
                        input string tag, input bit disturb);
        fmt = f; pix_r = r; pix_g = g; pix_b = b;
        {ctl_spare, de, vsync, hsync} = c;
        for (int s = 0; s < 7; s++) begin
            for (int w = 0; w < gap; w++) begin
                bit_en = 1'b0;
                @(negedge clk);
            end
            bit_en = 1'b1;
            #1;
            check(load_o == (s == 0), "R7 load strobe", 8'(load_o), 8'(s == 0));
            if (s == 0) begin
                for (int t = 0; t < 7; t++) q.push_back('{exp_slot(f, r, g, b, c, t), tag});
            end
            if (disturb && s == 3) begin
                fmt = ~f; pix_r = ~r; pix_g = ~g; pix_b = ~b;
                {ctl_spare, de, vsync, hsync} = ~c;
            end
            @(negedge clk);
        end
        bit_en = 1'b0;
    endtask

    always @(posedge clk) en_prev <= bit_en && rst_n;

    // monitor / scoreboard
    always @(negedge clk) begin
        logic [4:0] now;
        exp_t e;
        now = {clk_lane_o, lane_o};
        if (started) begin
            if (en_prev) begin
                if (q.size() == 0) begin
                    check(1'b0, "R9 unexpected slot", 8'(now), 8'h0);
                end else begin
                    e = q.pop_front();
                    check(now[4] == e.v[4], {"R2 clock lane ", e.tag}, 8'(now[4]), 8'(e.v[4]));
                    check(now[3:0] == e.v[3:0], {"R9 lanes ", e.tag}, 8'(now[3:0]), 8'(e.v[3:0]));
                end
            end else begin
                check(now == last_out, "R1 hold without strobe", 8'(now), 8'(last_out));
            end
        end
        last_out = now;
    end

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        fmt = 2'b01; pix_r = 8'hFF; pix_g = 8'hFF; pix_b = 8'hFF;
        repeat (4) @(negedge clk);
        check({clk_lane_o, lane_o} == 5'd0, "R8 reset outputs", 8'({clk_lane_o, lane_o}), 8'h0);
        bit_en = 1'b1;
        @(negedge clk);
        check({clk_lane_o, lane_o} == 5'd0, "R8 reset ignores strobe",
              8'({clk_lane_o, lane_o}), 8'h0);
        bit_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        started = 1'b1;
        @(negedge clk);
        check({clk_lane_o, lane_o} == 5'd0, "R8 idle after reset", 8'({clk_lane_o, lane_o}), 8'h0);

        // R3: 18-bit with bits 7..6 and CTL3 set that must be ignored
        send(2'b00, 8'hC5, 8'h6A, 8'hD3, 4'b1101, 0, "R3", 1'b0);
        send(2'b11, 8'h2D, 8'hF0, 8'h96, 4'b1010, 1, "R3 alt", 1'b0);
        // R4 / R5 with distinct patterns and strobe spacings
        send(2'b01, 8'hA5, 8'h3C, 8'h81, 4'b1011, 0, "R4", 1'b0);
        send(2'b01, 8'h5A, 8'hC3, 8'h7E, 4'b0100, 2, "R4", 1'b0);
        send(2'b10, 8'hA5, 8'h3C, 8'h81, 4'b1011, 0, "R5", 1'b0);
        send(2'b10, 8'h0F, 8'hE1, 8'h4B, 4'b0110, 3, "R5", 1'b0);
        // R6: walk a single control bit through each position
        send(2'b01, 8'h00, 8'h00, 8'h00, 4'b0001, 0, "R6 hsync", 1'b0);
        send(2'b01, 8'h00, 8'h00, 8'h00, 4'b0010, 0, "R6 vsync", 1'b0);
        send(2'b10, 8'h00, 8'h00, 8'h00, 4'b0100, 0, "R6 de", 1'b0);
        send(2'b10, 8'h00, 8'h00, 8'h00, 4'b1000, 0, "R6 spare", 1'b0);
        // R7: inputs and mode flipped mid-pixel
        send(2'b01, 8'h93, 8'h27, 8'hE8, 4'b1001, 0, "R7 mid change", 1'b1);
        send(2'b10, 8'h71, 8'h8C, 8'h35, 4'b0110, 1, "R7 mid change", 1'b1);
        send(2'b00, 8'hFF, 8'hFF, 8'hFF, 4'b1111, 0, "R3 lane3 idle", 1'b0);

        repeat (6) @(negedge clk);
        check(q.size() == 0, "R9 all slots sent", 8'(q.size()), 8'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule